// File: doc/BRIEF.md
# Per-Line Slice Mode Selector

This block decides, once per video line, which data-slicing service is applied to that line and with which handling options. It holds a small table of nine entries, each pairing a line number with an eight-bit mode byte. It also holds a full-field fallback mode and an enable for that fallback. When a line begins, the current line number, field and vertical-blanking flag are matched against the table. The winning mode byte is captured and held until the next line begins.

The held mode byte is split into decoded controls for the slicer that sits downstream:
- service code
- null-byte filter enable
- FIFO routing
- rejection of errored data
- error detection and correction enable
- slice-valid

The table and the fallback registers are programmed through a plain byte-wide write port. No interface carries a data stream, so every pin is plain control or status and no valid/ready handshake exists. The strobe and the write port are single-cycle pulses that are always accepted.

Top module: `line_mode_sel`

## Requirements
- R1: After reset every table line number is 00h and every table mode is FFh. The fallback mode is FFh and the fallback is disabled. The held mode is FFh, so slice-valid is 0.
- R2: A write at offset 2k sets the line number of entry k, and a write at offset 2k+1 sets its mode, for k from 0 to 8. Offset 18 sets the fallback mode and bit 0 of a write at offset 19 sets the fallback enable. Writes at offsets 20 to 31 change nothing.
- R3: During vertical blanking (in_vbi=1), entry k matches when all of the following hold: its mode is not FFh, its line number equals line_num, and its mode bit 3 equals field_id (0 = first field, 1 = second field). An entry whose mode is FFh never matches.
- R4: When several entries match, the entry with the lowest index supplies the mode.
- R5: During vertical blanking with no matching entry, the selected mode is the fallback mode if the fallback is enabled, and FFh otherwise.
- R6: Outside vertical blanking (in_vbi=0), the table is not consulted. The selected mode is the fallback mode if enabled, and FFh otherwise.
- R7: The selected mode appears on mode_q on the clock edge that samples line_start=1. It stays unchanged while line_start=0, whatever the line inputs or table writes do.
- R8: svc_code equals mode_q[2:0]. filt_en equals mode_q[7], and err_reject equals mode_q[5]; both are forced to 0 when slice-valid is 0.
- R9: fifo_route is 1 when slice-valid is 1 and either mode_q[6] is 1 or the service code is 000 (teletext).
- R10: edc_en is 1 only when slice-valid is 1, mode_q[4] is 1 and the service code is 000.
- R11: slice_valid is 1 exactly when mode_q is not FFh and mode_q[2:0] is not 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| line_start | input | 1 | One-cycle pulse at the start of a line |
| line_num | input | 8 | Current line number |
| field_id | input | 1 | Current field, 0 first, 1 second |
| in_vbi | input | 1 | Line lies in vertical blanking |
| mode_q | output | 8 | Held mode byte for the current line |
| svc_code | output | 3 | Service code |
| filt_en | output | 1 | Null-byte filter enable |
| fifo_route | output | 1 | Send sliced data to the FIFO |
| err_reject | output | 1 | Keep errored data out of the FIFO |
| edc_en | output | 1 | Error detection and correction enable |
| slice_valid | output | 1 | A service is to be sliced on this line |

## Verification
The assertions assume the following about the inputs:
- line_start is a single-cycle pulse.
- line_num, field_id and in_vbi are steady in the cycle that line_start samples them.
- Configuration writes complete before the strobe they are meant to affect.

The stimulus drives every input half a cycle away from the sampling edge. It never issues a write in the same cycle as a strobe, so the expected mode is always computed from a settled table.

Random table contents use a narrow band of line numbers so that duplicate and empty matches occur often. The directed cases then cover each of the following:
- the fallback default value
- lines outside blanking
- service code 111
- teletext routing with the routing bit clear
- writes to unused offsets

// File: rtl/lms_pkg.sv
package lms_pkg;
  localparam int LINE_W = 8;
  localparam int MODE_W = 8;

  typedef enum logic [2:0] {
    SVC_TTX  = 3'd0,
    SVC_CC   = 3'd1,
    SVC_WSS  = 3'd2,
    SVC_VITC = 3'd3,
    SVC_VPS  = 3'd4,
    SVC_USR1 = 3'd5,
    SVC_USR2 = 3'd6,
    SVC_NONE = 3'd7
  } svc_e;

  typedef struct packed {
    logic       filt;
    logic       fifo;
    logic       errrej;
    logic       edc;
    logic       fld2;
    logic [2:0] svc;
  } mode_s;

  localparam logic [MODE_W-1:0] MODE_EMPTY = 8'hFF;
endpackage

// File: rtl/lms_cfg.sv
module lms_cfg
  import lms_pkg::*;
#(
  parameter int N_ENTRY = 9,
  parameter int ADDR_W  = 5
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [7:0]                          wdata,
  output logic [N_ENTRY-1:0][LINE_W-1:0]      ent_line,
  output mode_s [N_ENTRY-1:0]                 ent_mode,
  output logic                                ff_en,
  output mode_s                               ff_mode
);
  localparam logic [ADDR_W-1:0] OFS_FFMODE = ADDR_W'(2 * N_ENTRY);
  localparam logic [ADDR_W-1:0] OFS_FFEN   = ADDR_W'(2 * N_ENTRY + 1);

  for (genvar k = 0; k < N_ENTRY; k++) begin : g_ent
    localparam logic [ADDR_W-1:0] OFS_LINE = ADDR_W'(2 * k);
    localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(2 * k + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_line[k] <= '0;
        ent_mode[k] <= mode_s'(MODE_EMPTY);
      end else if (we) begin
        if (addr == OFS_LINE) ent_line[k] <= wdata;
        if (addr == OFS_MODE) ent_mode[k] <= mode_s'(wdata);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_en   <= 1'b0;
      ff_mode <= mode_s'(MODE_EMPTY);
    end else if (we) begin
      if (addr == OFS_FFMODE) ff_mode <= mode_s'(wdata);
      if (addr == OFS_FFEN)   ff_en   <= wdata[0];
    end
  end
endmodule

// File: rtl/lms_match.sv
module lms_match
  import lms_pkg::*;
#(
  parameter int N_ENTRY = 9
) (
  input  logic [N_ENTRY-1:0][LINE_W-1:0] ent_line,
  input  mode_s [N_ENTRY-1:0]            ent_mode,
  input  logic                           ff_en,
  input  mode_s                          ff_mode,
  input  logic [LINE_W-1:0]              line_num,
  input  logic                           field_id,
  input  logic                           in_vbi,
  output mode_s                          next_mode,
  output logic                           tbl_hit
);
  logic [N_ENTRY-1:0] hit_vec;
  mode_s              win_mode;

  for (genvar k = 0; k < N_ENTRY; k++) begin : g_cmp
    assign hit_vec[k] = in_vbi
                      && (ent_mode[k] != mode_s'(MODE_EMPTY))
                      && (ent_line[k] == line_num)
                      && (ent_mode[k].fld2 == field_id);
  end

  // Scan from the top so the lowest matching index is the last to assign.
  always_comb begin
    win_mode = mode_s'(MODE_EMPTY);
    for (int k = N_ENTRY - 1; k >= 0; k--) begin
      if (hit_vec[k]) win_mode = ent_mode[k];
    end
  end

  assign tbl_hit   = |hit_vec;
  assign next_mode = tbl_hit ? win_mode
                   : (ff_en ? ff_mode : mode_s'(MODE_EMPTY));
endmodule

// File: rtl/lms_out.sv
module lms_out
  import lms_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start,
  input  mode_s       next_mode,
  input  logic        tbl_hit,
  input  logic        in_vbi,
  input  logic        ff_en,
  output logic [7:0]  mode_q,
  output logic [2:0]  svc_code,
  output logic        filt_en,
  output logic        fifo_route,
  output logic        err_reject,
  output logic        edc_en,
  output logic        slice_valid
);
  mode_s held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          held <= mode_s'(MODE_EMPTY);
    else if (line_start) held <= next_mode;
  end

  logic is_ttx;
  assign is_ttx      = (held.svc == SVC_TTX);
  assign mode_q      = held;
  assign svc_code    = held.svc;
  assign slice_valid = (held != mode_s'(MODE_EMPTY)) && (held.svc != SVC_NONE);
  assign filt_en     = slice_valid && held.filt;
  assign err_reject  = slice_valid && held.errrej;
  assign fifo_route  = slice_valid && (held.fifo || is_ttx);
  assign edc_en      = slice_valid && held.edc && is_ttx;

  // R7: held mode only moves on a line strobe
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(mode_q));

  // R3: a table hit never yields the empty mode
  a_r3_hit_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && tbl_hit) |=> (mode_q != 8'hFF));

  // R6: outside blanking with no fallback, nothing is sliced
  a_r6_outside_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !in_vbi && !ff_en) |=> (mode_q == 8'hFF));

  // R11: slice-valid never accompanies an empty or reserved mode
  a_r11_valid_mode: assert property (@(posedge clk) disable iff (!rst_n)
    slice_valid |-> (mode_q != 8'hFF && mode_q[2:0] != 3'b111));

  // R9: teletext always goes to the FIFO
  a_r9_ttx_fifo: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_valid && svc_code == 3'b000) |-> fifo_route);

  // R10: correction only for a valid teletext line
  a_r10_edc_ttx: assert property (@(posedge clk) disable iff (!rst_n)
    edc_en |-> (slice_valid && svc_code == 3'b000));
endmodule

// File: rtl/line_mode_sel.sv
module line_mode_sel
  import lms_pkg::*;
#(
  parameter  int N_ENTRY = 9,
  localparam int ADDR_W  = $clog2(2 * N_ENTRY + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              line_start,
  input  logic [7:0]        line_num,
  input  logic              field_id,
  input  logic              in_vbi,
  output logic [7:0]        mode_q,
  output logic [2:0]        svc_code,
  output logic              filt_en,
  output logic              fifo_route,
  output logic              err_reject,
  output logic              edc_en,
  output logic              slice_valid
);
  logic [N_ENTRY-1:0][LINE_W-1:0] ent_line;
  mode_s [N_ENTRY-1:0]            ent_mode;
  logic                           ff_en;
  mode_s                          ff_mode;
  mode_s                          next_mode;
  logic                           tbl_hit;

  lms_cfg #(.N_ENTRY(N_ENTRY), .ADDR_W(ADDR_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .ent_line (ent_line),
    .ent_mode (ent_mode),
    .ff_en    (ff_en),
    .ff_mode  (ff_mode)
  );

  lms_match #(.N_ENTRY(N_ENTRY)) u_match (
    .ent_line  (ent_line),
    .ent_mode  (ent_mode),
    .ff_en     (ff_en),
    .ff_mode   (ff_mode),
    .line_num  (line_num),
    .field_id  (field_id),
    .in_vbi    (in_vbi),
    .next_mode (next_mode),
    .tbl_hit   (tbl_hit)
  );

  lms_out u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .next_mode   (next_mode),
    .tbl_hit     (tbl_hit),
    .in_vbi      (in_vbi),
    .ff_en       (ff_en),
    .mode_q      (mode_q),
    .svc_code    (svc_code),
    .filt_en     (filt_en),
    .fifo_route  (fifo_route),
    .err_reject  (err_reject),
    .edc_en      (edc_en),
    .slice_valid (slice_valid)
  );
endmodule

// File: tb/tb_line_mode_sel.sv
module tb_line_mode_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       line_start = 1'b0;
  logic [7:0] line_num = '0;
  logic       field_id = 1'b0;
  logic       in_vbi = 1'b0;
  logic [7:0] mode_q;
  logic [2:0] svc_code;
  logic       filt_en, fifo_route, err_reject, edc_en, slice_valid;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_line [9];
  logic [7:0] m_mode [9];
  logic       m_ffen;
  logic [7:0] m_ffmode;

  always #5 clk = ~clk;

  line_mode_sel dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .line_start(line_start), .line_num(line_num),
    .field_id(field_id), .in_vbi(in_vbi), .mode_q(mode_q),
    .svc_code(svc_code), .filt_en(filt_en), .fifo_route(fifo_route),
    .err_reject(err_reject), .edc_en(edc_en), .slice_valid(slice_valid)
  );

  function automatic logic [7:0] exp_mode(logic [7:0] ln, logic f, logic vbi);
    if (vbi) begin
      for (int k = 0; k < 9; k++) begin
        if (m_mode[k] != 8'hFF && m_line[k] == ln && m_mode[k][3] == f)
          return m_mode[k];
      end
    end
    return m_ffen ? m_ffmode : 8'hFF;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_out(logic [7:0] m, string req);
    logic v;
    v = (m != 8'hFF) && (m[2:0] != 3'b111);
    chk(req, "mode_q", int'(mode_q), int'(m));
    chk("R11", "slice_valid", int'(slice_valid), int'(v));
    chk("R8", "svc_code", int'(svc_code), int'(m[2:0]));
    chk("R8", "filt_en", int'(filt_en), int'(v & m[7]));
    chk("R8", "err_reject", int'(err_reject), int'(v & m[5]));
    chk("R9", "fifo_route", int'(fifo_route), int'(v & (m[6] | (m[2:0] == 3'b000))));
    chk("R10", "edc_en", int'(edc_en), int'(v & m[4] & (m[2:0] == 3'b000)));
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 18) begin
      if (a % 2 == 0) m_line[a/2] = d; else m_mode[a/2] = d;
    end else if (a == 18) m_ffmode = d;
    else if (a == 19) m_ffen = d[0];
  endtask

  task automatic run_line(logic [7:0] ln, logic f, logic vbi, string req);
    logic [7:0] e;
    e = exp_mode(ln, f, vbi);
    @(negedge clk);
    line_num = ln; field_id = f; in_vbi = vbi; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    check_out(e, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd2024));
    for (int k = 0; k < 9; k++) begin m_line[k] = 8'h00; m_mode[k] = 8'hFF; end
    m_ffen = 1'b0; m_ffmode = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_out(8'hFF, "R1");
    run_line(8'd0, 1'b0, 1'b1, "R1");
    wr(19, 8'h01);
    run_line(8'd50, 1'b0, 1'b0, "R1");
    wr(19, 8'h00);

    // R3: line and field both matter
    wr(0, 8'd21); wr(1, 8'hA1);
    wr(2, 8'd21); wr(3, 8'h09);
    run_line(8'd21, 1'b0, 1'b1, "R3");
    run_line(8'd21, 1'b1, 1'b1, "R3");
    run_line(8'd22, 1'b0, 1'b1, "R3");
    run_line(8'd21, 1'b0, 1'b0, "R6");
    // R4: duplicate match, lowest entry wins
    wr(10, 8'd21); wr(11, 8'h03);
    run_line(8'd21, 1'b0, 1'b1, "R4");
    wr(1, 8'hFF);
    run_line(8'd21, 1'b0, 1'b1, "R3");
    // R5 / R6: fallback
    wr(18, 8'h30); wr(19, 8'h01);
    run_line(8'd99, 1'b0, 1'b0, "R6");
    run_line(8'd77, 1'b1, 1'b1, "R5");
    run_line(8'd21, 1'b0, 1'b1, "R5");
    wr(19, 8'h00);
    run_line(8'd77, 1'b1, 1'b1, "R5");
    // R11: reserved service
    wr(12, 8'd30); wr(13, 8'h07);
    run_line(8'd30, 1'b0, 1'b1, "R11");
    // R9 / R10: teletext without routing bit; non-teletext with correction bit
    wr(14, 8'd31); wr(15, 8'h10);
    run_line(8'd31, 1'b0, 1'b1, "R9");
    wr(16, 8'd32); wr(17, 8'h53);
    run_line(8'd32, 1'b0, 1'b1, "R10");
    // R2: unused offsets change nothing
    for (int a = 20; a < 32; a++) wr(a, 8'h00);
    run_line(8'd31, 1'b0, 1'b1, "R2");
    run_line(8'd21, 1'b0, 1'b1, "R2");
    run_line(8'd99, 1'b0, 1'b0, "R2");
    // R7: hold across input changes and table writes
    run_line(8'd31, 1'b0, 1'b1, "R7");
    held = mode_q;
    @(negedge clk); line_num = 8'd21; field_id = 1'b1;
    wr(15, 8'h01);
    repeat (3) @(negedge clk);
    chk("R7", "mode_q held", int'(mode_q), int'(held));
    run_line(8'd31, 1'b0, 1'b1, "R7");

    // random mix
    for (int it = 0; it < 600; it++) begin
      if ($urandom_range(0, 2) == 0) begin
        int a;
        logic [7:0] d;
        a = $urandom_range(0, 21);
        if (a < 18 && a % 2 == 0) d = 8'(10 + $urandom_range(0, 3));
        else if ($urandom_range(0, 3) == 0) d = 8'hFF;
        else d = 8'($urandom_range(0, 255));
        wr(a, d);
      end else begin
        run_line(8'(9 + $urandom_range(0, 5)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 3) != 0), "R4");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule